// File: doc/BRIEF.md
# Half-Duplex Transmit Collision Supervisor

This block supervises the transmit side of a half-duplex Ethernet MAC. It holds each new frame until the medium is quiet. It then tells the transmitter when to begin an attempt and watches the collision input while the attempt runs. Bytes are counted from the first preamble nibble, so each collision can be sorted as normal or late. A normal collision gets a jam and then a randomised backoff before the retry. A late collision, or too many collisions, ends the frame.

The transmitter pulses `frameReq` when a frame is ready. The supervisor answers with `txStart` for every attempt. The transmitter pulses `txDone` when the last nibble of an attempt has gone out. If a collision occurs first, the supervisor raises `txJam` and the transmitter sends jam nibbles instead of frame data. After each frame the supervisor can wait for the transceiver's heartbeat pulse on the collision line. It gates the receiver while sending, and it ends every frame with a one-cycle `frameDone` pulse and a status vector. Five static mode inputs select these behaviours:

- forced collisions on every attempt
- backoff freeze while carrier is sensed
- a 56-byte or 64-byte late window
- the heartbeat check
- open or blocked receive during transmit

Top module: `hdx_colsup`

## Requirements
- R1: After reset, `txStart`, `txJam`, `rxBlock`, `frameDone` and all status outputs are 0, and every mode input is expected to be driven 0.
- R2: The transmit clock moves one nibble, so two clocks make one byte. Clocks in an attempt are numbered from 0, where clock 0 is the first cycle after the `txStart` cycle. A collision seen at clock 2*64 or later is late, and one at clock 127 or earlier is normal, when `modeShortWindow` is 0.
- R3: With `modeShortWindow` = 1, the late threshold is clock 2*56 = 112: clock 111 is normal and clock 112 is late.
- R4: A normal collision raises `txJam` for exactly 8 cycles (32 bits) and then starts a retry. After collision n, the gap from the last jam cycle to the retry's `txStart` is 2 + r*SLOT_CLKS cycles, where 0 <= r <= 2^min(n,10) - 1 and r comes from an internal LFSR.
- R5: A late collision is jammed for 8 cycles, and the frame then ends with no retry. The status shows `stLate` = 1 and `stColCount` = 1.
- R6: With `modeForceCol` = 1, every attempt collides. The frame makes 16 attempts and ends with `stRetry` = 1 and `stColCount` = 16, meaning the retry limit of 15 was exceeded.
- R7: With `modeStopBackoff` = 1, the backoff count holds while `crs` is high, so a retry starts at least one cycle after carrier drops. With it at 0, the backoff keeps running, and a retry whose backoff already expired starts in the very cycle carrier drops.
- R8: With `modeHeartbeat` = 1, after `txDone` the block waits 40 clocks for `col`. A pulse on clocks 1 to 40 after the `txDone` cycle gives `stHbMiss` = 0. Otherwise `stHbMiss` = 1.
- R9: With `modeHeartbeat` = 0 there is no wait: `frameDone` pulses in the cycle right after `txDone`, with `stHbMiss` = 0.
- R10: `rxBlock` is 1 while an attempt or its jam is in progress when `modeRxOpen` = 0. It is always 0 when `modeRxOpen` = 1.
- R11: `frameDone` is a single-cycle pulse. The status outputs are cleared when a frame is accepted, and they hold their final values from the `frameDone` cycle until the next frame.
- R12: No attempt starts while `crs` is high. When `crs` falls, `txStart` rises in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, one nibble per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| modeForceCol | input | 1 | Treat every attempt as collided |
| modeStopBackoff | input | 1 | Freeze backoff while carrier is sensed |
| modeShortWindow | input | 1 | Use the 56-byte late threshold instead of 64 |
| modeHeartbeat | input | 1 | Check for a heartbeat after each frame |
| modeRxOpen | input | 1 | Keep receive open during transmit |
| frameReq | input | 1 | Pulse: a frame is ready to send |
| txDone | input | 1 | Pulse: last nibble of the attempt sent |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision / heartbeat from the transceiver |
| txStart | output | 1 | Pulse: begin an attempt with preamble |
| txJam | output | 1 | Send jam instead of frame data |
| rxBlock | output | 1 | Block the receive path |
| frameDone | output | 1 | Pulse: frame finished, status valid |
| stColCount | output | COL_W | Collisions counted for the frame |
| stLate | output | 1 | Frame aborted by a late collision |
| stRetry | output | 1 | Frame aborted after too many retries |
| stHbMiss | output | 1 | No heartbeat seen after the frame |

## Verification
Collisions are placed on the last normal clock and the first late clock for both window settings, so an off-by-one in the byte count or a wrong threshold is exposed. Heartbeat pulses are placed at 40 and at 41 clocks after `txDone`, and one frame has no pulse at all; this separates a correct window from one that is one cycle short or long. Forced collisions run a whole frame to the retry limit, which checks the attempt count, the jam length every time, and the backoff ceiling as it grows and then saturates. Carrier is held high across a backoff with the freeze mode off and then on, which tells a running counter from a held one by whether the retry starts in the very cycle carrier falls.

// File: rtl/hdx_colsup_pkg.sv
package hdx_colsup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEFER,
    ST_SEND,
    ST_JAM,
    ST_BACKOFF,
    ST_HBWAIT,
    ST_FIN
  } stateT;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrFrame;
    logic clrAttempt;
    logic incCol;
    logic ldJam;
    logic ldHb;
    logic ldBackoff;
    logic runBackoff;
    logic setLate;
    logic setRetry;
    logic setHbMiss;
  } strobeT;

  // Conditions from datapath to control
  typedef struct packed {
    logic lateNow;
    logic phaseZero;
    logic backoffDone;
    logic retryOver;
    logic lateSet;
  } flagT;

endpackage

// File: rtl/hdx_colsup_dpath.sv
module hdx_colsup_dpath
  import hdx_colsup_pkg::*;
#(
  parameter int SLOT_CLKS        = 128,
  parameter int JAM_CLKS         = 8,
  parameter int HB_CLKS          = 40,
  parameter int LATE_LONG_BYTES  = 64,
  parameter int LATE_SHORT_BYTES = 56,
  parameter int RETRY_LIMIT      = 15,
  parameter int BACKOFF_CAP      = 10,
  parameter int COL_W            = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeShortWindow,
  input  strobeT           stb,
  output flagT             flg,
  output logic [COL_W-1:0] stColCount,
  output logic             stLate,
  output logic             stRetry,
  output logic             stHbMiss
);

  localparam int LATE_MAX = 2 * LATE_LONG_BYTES;
  localparam int ATT_W    = $clog2(LATE_MAX + 1);
  localparam int PH_MAX   = (JAM_CLKS > HB_CLKS) ? JAM_CLKS : HB_CLKS;
  localparam int PH_W     = $clog2(PH_MAX + 1);
  localparam int SLOT_W   = $clog2(SLOT_CLKS + 1);
  localparam int LFSR_W   = 16;

  logic [ATT_W-1:0]       attCnt;
  logic [ATT_W-1:0]       lateLim;
  logic [PH_W-1:0]        phase;
  logic [SLOT_W-1:0]      subCnt;
  logic [BACKOFF_CAP-1:0] slotLeft;
  logic [BACKOFF_CAP-1:0] boMask;
  logic [LFSR_W-1:0]      lfsr;

  // Clock count inside an attempt, saturating above the long window
  always_ff @(posedge clk) begin
    if (!rstN || stb.clrAttempt) attCnt <= '0;
    else if (attCnt != ATT_W'(LATE_MAX)) attCnt <= attCnt + 1'b1;
  end

  assign lateLim = modeShortWindow ? ATT_W'(2 * LATE_SHORT_BYTES) : ATT_W'(LATE_MAX);

  // Shared down counter for jam and heartbeat windows
  always_ff @(posedge clk) begin
    if (!rstN)                phase <= '0;
    else if (stb.ldJam)       phase <= PH_W'(JAM_CLKS - 1);
    else if (stb.ldHb)        phase <= PH_W'(HB_CLKS - 1);
    else if (phase != '0)     phase <= phase - 1'b1;
  end

  // Free-running pseudo-random source
  always_ff @(posedge clk) begin
    if (!rstN) lfsr <= 16'hACE1;
    else       lfsr <= {lfsr[LFSR_W-2:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  // Truncated exponent: bit i of the mask is set while collisions exceed i
  always_comb begin
    for (int i = 0; i < BACKOFF_CAP; i++) boMask[i] = (stColCount > COL_W'(i));
  end

  // Backoff: slots remaining plus clocks within the slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotLeft <= '0;
      subCnt   <= '0;
    end else if (stb.ldBackoff) begin
      slotLeft <= lfsr[BACKOFF_CAP-1:0] & boMask;
      subCnt   <= '0;
    end else if (stb.runBackoff && slotLeft != '0) begin
      if (subCnt == SLOT_W'(SLOT_CLKS - 1)) begin
        subCnt   <= '0;
        slotLeft <= slotLeft - 1'b1;
      end else begin
        subCnt <= subCnt + 1'b1;
      end
    end
  end

  // Per-frame status
  always_ff @(posedge clk) begin
    if (!rstN || stb.clrFrame) begin
      stColCount <= '0;
      stLate     <= 1'b0;
      stRetry    <= 1'b0;
      stHbMiss   <= 1'b0;
    end else begin
      if (stb.incCol)    stColCount <= stColCount + 1'b1;
      if (stb.setLate)   stLate     <= 1'b1;
      if (stb.setRetry)  stRetry    <= 1'b1;
      if (stb.setHbMiss) stHbMiss   <= 1'b1;
    end
  end

  assign flg.lateNow     = (attCnt >= lateLim);
  assign flg.phaseZero   = (phase == '0);
  assign flg.backoffDone = (slotLeft == '0);
  assign flg.retryOver   = (stColCount > COL_W'(RETRY_LIMIT));
  assign flg.lateSet     = stLate;

endmodule

// File: rtl/hdx_colsup_ctrl.sv
module hdx_colsup_ctrl
  import hdx_colsup_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   modeForceCol,
  input  logic   modeStopBackoff,
  input  logic   modeHeartbeat,
  input  logic   modeRxOpen,
  input  logic   frameReq,
  input  logic   txDone,
  input  logic   crs,
  input  logic   col,
  input  flagT   flg,
  output strobeT stb,
  output logic   txStart,
  output logic   txJam,
  output logic   rxBlock,
  output logic   frameDone
);

  stateT state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    txStart   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (frameReq) begin
          stb.clrFrame = 1'b1;
          nextState    = ST_DEFER;
        end
      end
      ST_DEFER: begin
        if (!crs) begin
          txStart        = 1'b1;
          stb.clrAttempt = 1'b1;
          nextState      = ST_SEND;
        end
      end
      ST_SEND: begin
        if (col || modeForceCol) begin
          stb.incCol  = 1'b1;
          stb.ldJam   = 1'b1;
          stb.setLate = flg.lateNow;
          nextState   = ST_JAM;
        end else if (txDone) begin
          if (modeHeartbeat) begin
            stb.ldHb  = 1'b1;
            nextState = ST_HBWAIT;
          end else begin
            nextState = ST_FIN;
          end
        end
      end
      ST_JAM: begin
        if (flg.phaseZero) begin
          if (flg.lateSet) begin
            nextState = ST_FIN;
          end else if (flg.retryOver) begin
            stb.setRetry = 1'b1;
            nextState    = ST_FIN;
          end else begin
            stb.ldBackoff = 1'b1;
            nextState     = ST_BACKOFF;
          end
        end
      end
      ST_BACKOFF: begin
        if (!(modeStopBackoff && crs)) begin
          if (flg.backoffDone) nextState = ST_DEFER;
          else                 stb.runBackoff = 1'b1;
        end
      end
      ST_HBWAIT: begin
        if (col) begin
          nextState = ST_FIN;
        end else if (flg.phaseZero) begin
          stb.setHbMiss = 1'b1;
          nextState     = ST_FIN;
        end
      end
      ST_FIN: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign txJam     = (state == ST_JAM);
  assign rxBlock   = !modeRxOpen && (state == ST_SEND || state == ST_JAM);
  assign frameDone = (state == ST_FIN);

endmodule

// File: rtl/hdx_colsup.sv
module hdx_colsup
  import hdx_colsup_pkg::*;
#(
  parameter int SLOT_CLKS        = 128,
  parameter int JAM_CLKS         = 8,
  parameter int HB_CLKS          = 40,
  parameter int LATE_LONG_BYTES  = 64,
  parameter int LATE_SHORT_BYTES = 56,
  parameter int RETRY_LIMIT      = 15,
  parameter int BACKOFF_CAP      = 10,
  parameter int COL_W            = $clog2(RETRY_LIMIT + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeForceCol,
  input  logic             modeStopBackoff,
  input  logic             modeShortWindow,
  input  logic             modeHeartbeat,
  input  logic             modeRxOpen,
  input  logic             frameReq,
  input  logic             txDone,
  input  logic             crs,
  input  logic             col,
  output logic             txStart,
  output logic             txJam,
  output logic             rxBlock,
  output logic             frameDone,
  output logic [COL_W-1:0] stColCount,
  output logic             stLate,
  output logic             stRetry,
  output logic             stHbMiss
);

  strobeT stb;
  flagT   flg;

  hdx_colsup_ctrl u_ctrl (
    .clk             (clk),
    .rstN            (rstN),
    .modeForceCol    (modeForceCol),
    .modeStopBackoff (modeStopBackoff),
    .modeHeartbeat   (modeHeartbeat),
    .modeRxOpen      (modeRxOpen),
    .frameReq        (frameReq),
    .txDone          (txDone),
    .crs             (crs),
    .col             (col),
    .flg             (flg),
    .stb             (stb),
    .txStart         (txStart),
    .txJam           (txJam),
    .rxBlock         (rxBlock),
    .frameDone       (frameDone)
  );

  hdx_colsup_dpath #(
    .SLOT_CLKS        (SLOT_CLKS),
    .JAM_CLKS         (JAM_CLKS),
    .HB_CLKS          (HB_CLKS),
    .LATE_LONG_BYTES  (LATE_LONG_BYTES),
    .LATE_SHORT_BYTES (LATE_SHORT_BYTES),
    .RETRY_LIMIT      (RETRY_LIMIT),
    .BACKOFF_CAP      (BACKOFF_CAP),
    .COL_W            (COL_W)
  ) u_dpath (
    .clk             (clk),
    .rstN            (rstN),
    .modeShortWindow (modeShortWindow),
    .stb             (stb),
    .flg             (flg),
    .stColCount      (stColCount),
    .stLate          (stLate),
    .stRetry         (stRetry),
    .stHbMiss        (stHbMiss)
  );

endmodule

// File: rtl/hdx_colsup_chk.sv
module hdx_colsup_chk #(
  parameter int COL_W       = 5,
  parameter int RETRY_LIMIT = 15
) (
  input logic             clk,
  input logic             rstN,
  input logic             crs,
  input logic             modeRxOpen,
  input logic             txStart,
  input logic             txJam,
  input logic             rxBlock,
  input logic             frameDone,
  input logic [COL_W-1:0] stColCount,
  input logic             stLate,
  input logic             stRetry
);

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  a_r10_rx_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (txJam && !modeRxOpen) |-> rxBlock);

  a_r10_rx_open: assert property (@(posedge clk) disable iff (!rstN)
    modeRxOpen |-> !rxBlock);

  a_r6_retry_count: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && stRetry) |-> (stColCount == COL_W'(RETRY_LIMIT + 1)));

  a_r5_late_no_retry: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && stLate) |-> !stRetry);

  a_r12_defer_crs: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> !crs);

  a_r4_jam_no_start: assert property (@(posedge clk) disable iff (!rstN)
    txJam |-> !txStart);

endmodule

bind hdx_colsup hdx_colsup_chk #(.COL_W(COL_W), .RETRY_LIMIT(RETRY_LIMIT)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .crs        (crs),
  .modeRxOpen (modeRxOpen),
  .txStart    (txStart),
  .txJam      (txJam),
  .rxBlock    (rxBlock),
  .frameDone  (frameDone),
  .stColCount (stColCount),
  .stLate     (stLate),
  .stRetry    (stRetry)
);

// File: tb/hdx_colsup_bench.sv
module hdx_colsup_bench;

  localparam int SLOT  = 4;
  localparam int JAM   = 8;
  localparam int COLW  = 5;
  localparam int LEN   = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeForceCol = 0, modeStopBackoff = 0, modeShortWindow = 0;
  logic modeHeartbeat = 0, modeRxOpen = 0;
  logic frameReq = 0, txDone = 0, crs = 0, col = 0;
  logic txStart, txJam, rxBlock, frameDone, stLate, stRetry, stHbMiss;
  logic [COLW-1:0] stColCount;

  always #2 clk = ~clk;

  hdx_colsup #(.SLOT_CLKS(SLOT)) u_hdx_colsup (
    .clk(clk), .rstN(rstN),
    .modeForceCol(modeForceCol), .modeStopBackoff(modeStopBackoff),
    .modeShortWindow(modeShortWindow), .modeHeartbeat(modeHeartbeat),
    .modeRxOpen(modeRxOpen), .frameReq(frameReq), .txDone(txDone),
    .crs(crs), .col(col), .txStart(txStart), .txJam(txJam),
    .rxBlock(rxBlock), .frameDone(frameDone), .stColCount(stColCount),
    .stLate(stLate), .stRetry(stRetry), .stHbMiss(stHbMiss)
  );

  int nChk = 0, nFail = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: jam length, retry gaps, frame completion
  int cyc = 0, jamRun = 0, lastJamCyc = 0, starts = 0, gap = 0, gapLim = 0, nExp = 0;
  bit jamPrev = 0, monBo = 0, doneSeen = 0;
  int dCol = 0;
  bit dLate = 0, dRetry = 0, dHb = 0;

  always @(negedge clk) begin
    #1;
    cyc++;
    if (rstN) begin
      if (txJam) begin
        jamRun++;
        lastJamCyc = cyc;
      end else if (jamPrev) begin
        check(jamRun == JAM, "R4 jam length", jamRun, JAM);
        jamRun = 0;
      end
      jamPrev = txJam;
      if (txStart) begin
        starts++;
        if (monBo && starts > 1) begin
          nExp   = (starts - 1 > 10) ? 10 : starts - 1;
          gapLim = ((1 << nExp) - 1) * SLOT + 2;
          gap    = cyc - lastJamCyc;
          check(gap >= 2 && gap <= gapLim, "R4 backoff gap", gap, gapLim);
        end
      end
      if (frameDone) begin
        doneSeen = 1;
        dCol = int'(stColCount);
        dLate = stLate;
        dRetry = stRetry;
        dHb = stHbMiss;
      end
    end
  end

  task automatic waitStart();
    for (int i = 0; i < 20000; i++) begin
      #1;
      if (txStart) return;
      @(negedge clk);
    end
    check(0, "R12 txStart timeout", 0, 1);
  endtask

  task automatic waitDone();
    for (int i = 0; i < 60000; i++) begin
      if (doneSeen) return;
      @(negedge clk);
    end
    check(0, "R11 frameDone timeout", 0, 1);
  endtask

  task automatic request();
    starts = 0;
    doneSeen = 0;
    @(negedge clk);
    frameReq = 1;
    @(negedge clk);
    frameReq = 0;
  endtask

  task automatic sendBody();
    repeat (LEN) @(negedge clk);
    txDone = 1;
    @(negedge clk);
    txDone = 0;
  endtask

  typedef struct packed {
    bit force_;
    bit shortW;
    bit hbEn;
    int colAt;
    int hbDelay;
    bit expLate;
    bit expRetry;
    bit expHb;
    int expCol;
    int req;
  } vecT;

  localparam int NV = 10;
  localparam vecT VEC [NV] = '{
    '{0, 0, 0, -1,  0, 0, 0, 0,  0, 9},   // R9 clean frame
    '{0, 0, 1, -1, 40, 0, 0, 0,  0, 8},   // R8 heartbeat at last clock
    '{0, 0, 1, -1, 41, 0, 0, 1,  0, 8},   // R8 heartbeat one clock late
    '{0, 0, 1, -1,  0, 0, 0, 1,  0, 8},   // R8 no heartbeat
    '{0, 0, 0, 127, 0, 0, 0, 0,  1, 2},   // R2 last normal clock
    '{0, 0, 0, 128, 0, 1, 0, 0,  1, 2},   // R2 first late clock, R5
    '{0, 1, 0, 111, 0, 0, 0, 0,  1, 3},   // R3 last normal clock
    '{0, 1, 0, 112, 0, 1, 0, 0,  1, 3},   // R3 first late clock, R5
    '{0, 0, 0,  0,  0, 0, 0, 0,  1, 4},   // R4 early collision then retry
    '{1, 0, 0, -1,  0, 0, 1, 0, 16, 6}    // R6 forced collisions
  };

  int k;

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    #1;
    check(!txStart && !txJam && !rxBlock && !frameDone, "R1 reset outputs", int'(txStart | txJam | rxBlock | frameDone), 0);
    check(stColCount == 0 && !stLate && !stRetry && !stHbMiss, "R1 reset status", int'(stColCount), 0);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    #1;
    check(!txStart && !txJam && !rxBlock && !frameDone, "R1 idle after reset", int'(txStart | rxBlock), 0);

    // Vector table
    foreach (VEC[i]) begin
      vecT v;
      v = VEC[i];
      modeForceCol    = v.force_;
      modeShortWindow = v.shortW;
      modeHeartbeat   = v.hbEn;
      monBo = 1;
      request();
      if (!v.force_) begin
        waitStart();
        if (v.colAt >= 0) begin
          repeat (v.colAt + 1) @(negedge clk);
          col = 1;
          @(negedge clk);
          col = 0;
          if (!v.expLate) waitStart();
        end
        if (!v.expLate) begin
          sendBody();
          if (v.hbDelay > 0) begin
            repeat (v.hbDelay - 1) @(negedge clk);
            col = 1;
            @(negedge clk);
            col = 0;
          end
        end
      end
      waitDone();
      check(dLate == v.expLate, $sformatf("R%0d row %0d late flag", v.req, i), int'(dLate), int'(v.expLate));
      check(dRetry == v.expRetry, $sformatf("R%0d row %0d retry flag", v.req, i), int'(dRetry), int'(v.expRetry));
      check(dHb == v.expHb, $sformatf("R%0d row %0d heartbeat flag", v.req, i), int'(dHb), int'(v.expHb));
      check(dCol == v.expCol, $sformatf("R%0d row %0d collision count", v.req, i), dCol, v.expCol);
      if (v.force_) check(starts == 16, "R6 attempts", starts, 16);
      if (v.expLate) check(starts == 1, "R5 no retry after late", starts, 1);
      @(negedge clk);
      #1;
      check(!frameDone, "R11 done single cycle", int'(frameDone), 0);
      check(dCol == int'(stColCount), "R11 status held", int'(stColCount), dCol);
      repeat (3) @(negedge clk);
    end
    modeForceCol = 0;
    modeShortWindow = 0;
    monBo = 0;

    // R9 frameDone right after txDone when heartbeat off; R8 waits when on
    for (int h = 0; h < 2; h++) begin
      modeHeartbeat = (h == 1);
      request();
      waitStart();
      repeat (LEN) @(negedge clk);
      txDone = 1;
      @(negedge clk);
      txDone = 0;
      #1;
      if (h == 0) check(frameDone == 1, "R9 done next cycle", int'(frameDone), 1);
      else        check(frameDone == 0, "R8 waits for heartbeat", int'(frameDone), 0);
      waitDone();
      repeat (3) @(negedge clk);
    end
    modeHeartbeat = 0;

    // R10 receive gating
    for (int r = 0; r < 2; r++) begin
      modeRxOpen = (r == 1);
      request();
      waitStart();
      @(negedge clk);
      #1;
      if (r == 0) check(rxBlock == 1, "R10 rx blocked in send", int'(rxBlock), 1);
      else        check(rxBlock == 0, "R10 rx open in send", int'(rxBlock), 0);
      sendBody();
      waitDone();
      #1;
      check(rxBlock == 0, "R10 rx free when idle", int'(rxBlock), 0);
      repeat (3) @(negedge clk);
    end
    modeRxOpen = 0;

    // R12 deferral
    crs = 1;
    request();
    k = 0;
    repeat (30) begin
      @(negedge clk);
      #1;
      if (txStart) k++;
    end
    check(k == 0, "R12 no start under carrier", k, 0);
    @(negedge clk);
    crs = 0;
    #1;
    check(txStart == 1, "R12 start when carrier falls", int'(txStart), 1);
    sendBody();
    waitDone();
    repeat (3) @(negedge clk);

    // R7 backoff freeze under carrier
    for (int s = 0; s < 2; s++) begin
      modeStopBackoff = (s == 1);
      request();
      waitStart();
      repeat (11) @(negedge clk);
      col = 1;
      crs = 1;
      @(negedge clk);
      col = 0;
      repeat (60) @(negedge clk);
      crs = 0;
      k = 0;
      for (int i = 0; i < 2000; i++) begin
        #1;
        if (txStart) break;
        @(negedge clk);
        k++;
      end
      if (s == 0) check(k == 0, "R7 free backoff starts at carrier drop", k, 0);
      else        check(k >= 1, "R7 frozen backoff starts later", k, 1);
      sendBody();
      waitDone();
      check(dCol == 1, "R7 one collision", dCol, 1);
      repeat (3) @(negedge clk);
    end
    modeStopBackoff = 0;

    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

endmodule